// File: doc/BRIEF.md
# Result Broadcast Bus Arbiter

In an out-of-order core, several execution units can finish in the same cycle, but only a small number of shared result channels exist. Every listener watches these channels for the tag it waits on. This block takes one pending result from each unit, filters out results that belong to cancelled instructions, chooses the oldest survivors by instruction age, and places each winner's tag and value on a broadcast channel in the following cycle.

A unit raises its request with a tag, a value and an age stamp. It keeps all of them steady until the arbiter answers with ready. Ready means the result was either granted a channel or discarded because a squash removed it. A unit that sees ready low has lost this cycle and competes again on the next one. A squash carries an age boundary, and every pending request younger than that boundary is removed in the same cycle.

Top module: `result_bcast_arb`

## Requirements
- R1: A request granted in cycle t appears on a channel in cycle t+1, with that channel's valid bit high and the requester's tag and value.
- R2: The number of channels is set by the parameter NUM_CH (1 or 2, default 2). No more than NUM_CH requests are granted per cycle.
- R3: Age stamps are AGE_W bits wide and wrap. Age a is older than age b when bit AGE_W-1 of (a - b) modulo 2^AGE_W is 1. The oldest eligible requests win, and the oldest winner goes to channel 0 and the next oldest to channel 1.
- R4: When two eligible requests carry equal ages, the one with the lower unit index ranks as older.
- R5: A valid request that is neither granted nor squashed sees its ready bit at 0. It must hold its tag, value and age, and it competes again on the next cycle.
- R6: A channel that has no winner for a cycle drives its valid bit at 0 in the following cycle.
- R7: While squash_valid is 1, a valid request whose age is younger than squash_age (squash_age is older than it under R3) gets ready 1 in that cycle and never reaches a channel. Requests whose age equals the boundary or is older than it are unaffected.
- R8: Squashed requests occupy no channel. If only one request survives the squash, only channel 0 is valid in the next cycle.
- R9: After reset all channel valid bits are 0. A unit whose request valid bit is 0 sees ready 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_UNITS | Per-unit request present |
| req_tag | input | NUM_UNITS*TAG_W | Per-unit result tag; unit i at bits [i*TAG_W +: TAG_W] |
| req_data | input | NUM_UNITS*DATA_W | Per-unit result value; unit i at bits [i*DATA_W +: DATA_W] |
| req_age | input | NUM_UNITS*AGE_W | Per-unit age stamp; unit i at bits [i*AGE_W +: AGE_W] |
| req_ready | output | NUM_UNITS | Per-unit request consumed (granted or squashed) this cycle |
| squash_valid | input | 1 | A squash is in effect this cycle |
| squash_age | input | AGE_W | Squash boundary; younger requests are removed |
| ch_valid | output | NUM_CH | Per-channel broadcast valid |
| ch_tag | output | NUM_CH*TAG_W | Per-channel tag; channel k at bits [k*TAG_W +: TAG_W] |
| ch_data | output | NUM_CH*DATA_W | Per-channel value; channel k at bits [k*DATA_W +: DATA_W] |

## Verification
The only state is the channel register, so a wrong ranking or a stale entry shows on the channel ports exactly one cycle after the inputs that caused it. An error in the squash filter or in the ranking also shows at once, in the same cycle, as a wrong req_ready pattern. The directed scenarios therefore check req_ready before each clock edge and then check the channel tags and values after that edge. They cover wrapped ages, ties, losers retrying and a squash that leaves only one survivor, so a misrouted winner, a dropped loser or a leaked squashed result shows up within one cycle.

// File: rtl/rba_pkg.sv
package rba_pkg;
    localparam int DEF_UNITS  = 4;
    localparam int DEF_CH     = 2;
    localparam int DEF_TAG_W  = 6;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_AGE_W  = 5;
endpackage

// File: rtl/rba_squash_filter.sv
module rba_squash_filter #(
    parameter int N     = rba_pkg::DEF_UNITS,
    parameter int AGE_W = rba_pkg::DEF_AGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       req_valid,
    input  logic [N*AGE_W-1:0] req_age,
    input  logic               squash_valid,
    input  logic [AGE_W-1:0]   squash_age,
    output logic [N-1:0]       elig,
    output logic [N-1:0]       drop
);
    logic [AGE_W-1:0] diff [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            // boundary older than request -> request is younger -> removed
            diff[i] = squash_age - req_age[i*AGE_W +: AGE_W];
            drop[i] = req_valid[i] && squash_valid && diff[i][AGE_W-1];
            elig[i] = req_valid[i] && !drop[i];
        end
    end

    assert_no_drop_without_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_valid |-> (drop == '0));
endmodule

// File: rtl/rba_rank.sv
module rba_rank #(
    parameter int N      = rba_pkg::DEF_UNITS,
    parameter int NUM_CH = rba_pkg::DEF_CH,
    parameter int AGE_W  = rba_pkg::DEF_AGE_W,
    localparam int RW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       elig,
    input  logic [N*AGE_W-1:0] req_age,
    output logic [N-1:0]       win,
    output logic [N*RW-1:0]    rank
);
    logic [AGE_W-1:0] age [N];
    logic [N-1:0]     beats [N];  // beats[i][j]: unit j ranks ahead of unit i

    function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return d[AGE_W-1];
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) age[i] = req_age[i*AGE_W +: AGE_W];
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                beats[i][j] = (j != i) && elig[j] &&
                              (older(age[j], age[i]) || ((age[j] == age[i]) && (j < i)));
            end
        end
    end

    genvar gi, gj;
    generate
        for (gi = 0; gi < N; gi++) begin : g_unit
            logic [RW:0] cnt;
            always_comb begin
                cnt = '0;
                for (int j = 0; j < N; j++) cnt = cnt + {{RW{1'b0}}, beats[gi][j]};
                win[gi] = elig[gi] && (cnt < (RW+1)'(NUM_CH));
                rank[gi*RW +: RW] = cnt[RW-1:0];
            end
            for (gj = 0; gj < N; gj++) begin : g_pair
                if (gi != gj) begin : g_chk
                    assert_loser_not_older_R3: assert property (@(posedge clk) disable iff (!rst_n)
                        (win[gi] && elig[gj] && !win[gj]) |-> !older(age[gj], age[gi]));
                end
            end
        end
    endgenerate

    assert_grant_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win) <= NUM_CH);
    assert_fill_channels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(elig) >= NUM_CH) |-> ($countones(win) == NUM_CH));
endmodule

// File: rtl/result_bcast_arb.sv
module result_bcast_arb #(
    parameter int NUM_UNITS = rba_pkg::DEF_UNITS,
    parameter int NUM_CH    = rba_pkg::DEF_CH,
    parameter int TAG_W     = rba_pkg::DEF_TAG_W,
    parameter int DATA_W    = rba_pkg::DEF_DATA_W,
    parameter int AGE_W     = rba_pkg::DEF_AGE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_UNITS-1:0]        req_valid,
    input  logic [NUM_UNITS*TAG_W-1:0]  req_tag,
    input  logic [NUM_UNITS*DATA_W-1:0] req_data,
    input  logic [NUM_UNITS*AGE_W-1:0]  req_age,
    output logic [NUM_UNITS-1:0]        req_ready,
    input  logic                        squash_valid,
    input  logic [AGE_W-1:0]            squash_age,
    output logic [NUM_CH-1:0]           ch_valid,
    output logic [NUM_CH*TAG_W-1:0]     ch_tag,
    output logic [NUM_CH*DATA_W-1:0]    ch_data
);
    localparam int RW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0]        vld;
        logic [NUM_CH*TAG_W-1:0]  tag;
        logic [NUM_CH*DATA_W-1:0] data;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [NUM_UNITS-1:0]    elig, drop, win;
    logic [NUM_UNITS*RW-1:0] rank;

    rba_squash_filter #(.N(NUM_UNITS), .AGE_W(AGE_W)) u_filter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_age(req_age),
        .squash_valid(squash_valid), .squash_age(squash_age),
        .elig(elig), .drop(drop)
    );

    rba_rank #(.N(NUM_UNITS), .NUM_CH(NUM_CH), .AGE_W(AGE_W)) u_rank (
        .clk(clk), .rst_n(rst_n),
        .elig(elig), .req_age(req_age),
        .win(win), .rank(rank)
    );

    always_comb begin
        st_d = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            for (int i = 0; i < NUM_UNITS; i++) begin
                if (win[i] && (rank[i*RW +: RW] == RW'(k))) begin
                    st_d.vld[k]                   = 1'b1;
                    st_d.tag[k*TAG_W +: TAG_W]    = req_tag[i*TAG_W +: TAG_W];
                    st_d.data[k*DATA_W +: DATA_W] = req_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = win | drop;
    assign ch_valid  = st_q.vld;
    assign ch_tag    = st_q.tag;
    assign ch_data   = st_q.data;

    genvar gu, gk;
    generate
        for (gu = 0; gu < NUM_UNITS; gu++) begin : g_hold
            assert_loser_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[gu] && !req_ready[gu]) |=>
                (req_valid[gu] && $stable(req_tag[gu*TAG_W +: TAG_W]) &&
                 $stable(req_data[gu*DATA_W +: DATA_W])));
            assert_squashed_not_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
                drop[gu] |-> !win[gu]);
        end
        for (gk = 1; gk < NUM_CH; gk++) begin : g_pack
            assert_oldest_on_low_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ch_valid[gk] |-> ch_valid[gk-1]);
        end
    endgenerate

    assert_idle_channels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> (ch_valid == '0));
    assert_ready_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);
endmodule

// File: tb/sim_result_bcast_arb.sv
`timescale 1ns/1ps
module sim_result_bcast_arb;
    localparam int N = 4, C = 2, TW = 6, DW = 16, AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [N-1:0]    v;
    logic [AW-1:0]   age [N];
    logic [TW-1:0]   tg  [N];
    logic [DW-1:0]   dt  [N];
    logic [N*TW-1:0] req_tag;
    logic [N*DW-1:0] req_data;
    logic [N*AW-1:0] req_age;
    logic [N-1:0]    req_ready;
    logic            sq_v;
    logic [AW-1:0]   sq_age;
    logic [C-1:0]    ch_valid;
    logic [C*TW-1:0] ch_tag;
    logic [C*DW-1:0] ch_data;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_tag[i*TW +: TW]  = tg[i];
            req_data[i*DW +: DW] = dt[i];
            req_age[i*AW +: AW]  = age[i];
        end
    end

    result_bcast_arb #(.NUM_UNITS(N), .NUM_CH(C), .TAG_W(TW), .DATA_W(DW), .AGE_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_tag(req_tag), .req_data(req_data),
        .req_age(req_age), .req_ready(req_ready), .squash_valid(sq_v), .squash_age(sq_age),
        .ch_valid(ch_valid), .ch_tag(ch_tag), .ch_data(ch_data)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int u, input logic [AW-1:0] a);
        v[u] = 1'b1; age[u] = a;
        tg[u] = TW'(8 + u); dt[u] = DW'(16'hA000 + u * 16'h0111);
    endtask

    task automatic clear_all();
        v = '0; sq_v = 1'b0; sq_age = '0;
        for (int i = 0; i < N; i++) begin age[i] = '0; tg[i] = '0; dt[i] = '0; end
    endtask

    // expect channel k to carry unit u's result (u < 0 means channel idle)
    task automatic chk_ch(input string req, input int k, input int u);
        if (u < 0) chk({req, " idle channel"}, 32'(ch_valid[k]), 32'd0);
        else begin
            chk({req, " ch valid"}, 32'(ch_valid[k]), 32'd1);
            chk({req, " ch tag"},   32'(ch_tag[k*TW +: TW]), 32'(8 + u));
            chk({req, " ch data"},  32'(ch_data[k*DW +: DW]), 32'(16'hA000 + u * 16'h0111));
        end
    endtask

    task automatic t_reset();
        chk("R9 reset ch_valid", 32'(ch_valid), 32'd0);
        chk("R9 idle ready", 32'(req_ready), 32'd0);
    endtask

    task automatic t_single();
        @(negedge clk); clear_all(); put(2, 5'd3);
        #1 chk("R1 single ready", 32'(req_ready), 32'b0100);
        @(negedge clk);
        chk_ch("R1", 0, 2);
        chk_ch("R6", 1, -1);
    endtask

    task automatic t_oldest_and_retry();
        @(negedge clk); clear_all(); put(0, 5'd7); put(1, 5'd2); put(2, 5'd5);
        #1 chk("R3 ready oldest two", 32'(req_ready), 32'b0110);
        chk("R5 loser ready low", 32'(req_ready[0]), 32'd0);
        @(negedge clk);
        chk_ch("R3 ch0 oldest", 0, 1);
        chk_ch("R3 ch1 next", 1, 2);
        v[1] = 1'b0; v[2] = 1'b0;  // unit 0 holds its result
        #1 chk("R5 retry ready", 32'(req_ready), 32'b0001);
        @(negedge clk);
        chk_ch("R5 retried", 0, 0);
        chk_ch("R6 retry", 1, -1);
    endtask

    task automatic t_wrap();
        @(negedge clk); clear_all(); put(0, 5'd30); put(1, 5'd2); put(2, 5'd3); put(3, 5'd1);
        #1 chk("R3 wrap ready", 32'(req_ready), 32'b1001);
        @(negedge clk);
        chk_ch("R3 wrap ch0", 0, 0);
        chk_ch("R3 wrap ch1", 1, 3);
    endtask

    task automatic t_tie();
        @(negedge clk); clear_all(); put(1, 5'd4); put(2, 5'd9); put(3, 5'd4);
        #1 chk("R4 tie ready", 32'(req_ready), 32'b1010);
        @(negedge clk);
        chk_ch("R4 tie ch0", 0, 1);
        chk_ch("R4 tie ch1", 1, 3);
    endtask

    task automatic t_squash();
        @(negedge clk); clear_all(); put(0, 5'd6); put(1, 5'd7); put(2, 5'd2);
        sq_v = 1'b1; sq_age = 5'd4;
        #1 chk("R7 squash ready", 32'(req_ready), 32'b0111);
        @(negedge clk);
        chk_ch("R8 survivor", 0, 2);
        chk_ch("R8 no slot for squashed", 1, -1);
        clear_all();
        @(negedge clk);
        chk("R6 nothing after squash", 32'(ch_valid), 32'd0);
        // boundary equal to age is kept, squash of nothing younger
        put(3, 5'd9); put(0, 5'd8); sq_v = 1'b1; sq_age = 5'd9;
        #1 chk("R7 boundary kept", 32'(req_ready), 32'b1001);
        @(negedge clk);
        chk_ch("R7 boundary ch0", 0, 0);
        chk_ch("R7 boundary ch1", 1, 3);
        clear_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_single();
        t_oldest_and_retry();
        t_wrap();
        t_tie();
        t_squash();
        @(negedge clk);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            finish_run();
        end
    end
endmodule